// File: doc/BRIEF.md
# Integer ALU with Barrel Shifter

This block is the combinational execution unit for the register-register and register-immediate integer work of a small load/store processor. It takes two operands, a constant shift count and a five-bit operation code. It returns a result word, a flag that marks an all-zero result for equal and not-equal branch decisions, and a signed overflow flag that the trapping add and subtract forms raise.

The datapath has four units: an adder/subtractor that also produces a signed less-than, a bitwise logic unit, a logarithmic barrel shifter, and an upper-immediate placer. A decode function in the package turns the operation code into a control struct, and that struct selects the unit and its mode. Operand `opnd_b` holds the value to shift. A constant shift takes its count from `sh_const`. A variable shift takes its count from the low bits of `opnd_a`. Multiply, divide and their result registers are not part of this block.

Top module: `int_alu`

## Requirements
- R1: Codes 0 (trapping add) and 1 (non-trapping add) give `alu_out` = a + b modulo 2^32. Codes 2 (trapping subtract) and 3 (non-trapping subtract) give a - b modulo 2^32.
- R2: `sig_ovf` is 1 only for codes 0 and 2, and only when the exact signed sum or difference falls outside the 32-bit two's complement range. Codes 1 and 3, and every other code, give `sig_ovf` = 0.
- R3: Codes 4, 5, 6 and 7 give the bitwise a AND b, a OR b, a XOR b and NOT(a OR b).
- R4: Code 8 gives 1 when a is less than b as signed 32-bit integers and 0 otherwise. The result stays correct when a - b overflows.
- R5: Codes 9, 10 and 11 shift b by `sh_const`: left with zero fill, right with zero fill, and right with copies of b[31].
- R6: Codes 12, 13 and 14 shift b left, right-logical and right-arithmetic by a[4:0]. Bits a[31:5] and `sh_const` have no effect.
- R7: Code 15 gives b[15:0] in bits 31:16 and zeros in bits 15:0.
- R8: `is_zero` is 1 exactly when `alu_out` is all zeros, for every code.
- R9: Codes 16 to 31 give `alu_out` = 0 and `sig_ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand; its low 5 bits are the count for variable shifts |
| opnd_b | input | 32 | Second operand or immediate; the value that shifts shift |
| sh_const | input | 5 | Shift count for constant shifts |
| alu_op | input | 5 | Operation code |
| alu_out | output | 32 | Result word |
| is_zero | output | 1 | High when the result is all zeros |
| sig_ovf | output | 1 | Signed overflow of the trapping add and subtract forms |

## Verification
The embedded checks are immediate assertions on combinational values. They assume that every input is a settled two-state value whenever the checks evaluate. The bench therefore drives all inputs with defined values in a single step, one clock edge after the previous item, and compares the outputs half a period later. The shifter checks compare against a plain shift only for power-of-two widths, and the bench keeps the default width. Overflow and less-than are checked by widening the operands by one sign bit. For that reason the bench stimulus includes operands near both ends of the signed range.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADDU = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBU = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_NOR  = 5'd7,
        OP_SLT  = 5'd8,
        OP_SLL  = 5'd9,
        OP_SRL  = 5'd10,
        OP_SRA  = 5'd11,
        OP_SLLV = 5'd12,
        OP_SRLV = 5'd13,
        OP_SRAV = 5'd14,
        OP_LUI  = 5'd15
    } alu_op_e;

    typedef enum logic [2:0] {
        U_NONE,
        U_ARITH,
        U_LOGIC,
        U_SLT,
        U_SHIFT,
        U_UPPER
    } unit_e;

    typedef enum logic [1:0] {
        LG_AND,
        LG_OR,
        LG_XOR,
        LG_NOR
    } logic_e;

    typedef enum logic [1:0] {
        SH_LEFT,
        SH_RLOG,
        SH_RARI
    } shift_e;

    typedef struct packed {
        unit_e  unit;
        logic   sub;
        logic   trap;
        logic_e lg;
        shift_e sh;
        logic   var_amt;
    } ctrl_t;

    function automatic ctrl_t decode_op(input logic [4:0] code);
        ctrl_t c;
        c.unit    = U_NONE;
        c.sub     = 1'b0;
        c.trap    = 1'b0;
        c.lg      = LG_AND;
        c.sh      = SH_LEFT;
        c.var_amt = 1'b0;
        case (code)
            OP_ADD:  begin c.unit = U_ARITH; c.trap = 1'b1; end
            OP_ADDU: begin c.unit = U_ARITH; end
            OP_SUB:  begin c.unit = U_ARITH; c.sub = 1'b1; c.trap = 1'b1; end
            OP_SUBU: begin c.unit = U_ARITH; c.sub = 1'b1; end
            OP_AND:  begin c.unit = U_LOGIC; c.lg = LG_AND; end
            OP_OR:   begin c.unit = U_LOGIC; c.lg = LG_OR; end
            OP_XOR:  begin c.unit = U_LOGIC; c.lg = LG_XOR; end
            OP_NOR:  begin c.unit = U_LOGIC; c.lg = LG_NOR; end
            OP_SLT:  begin c.unit = U_SLT; c.sub = 1'b1; end
            OP_SLL:  begin c.unit = U_SHIFT; c.sh = SH_LEFT; end
            OP_SRL:  begin c.unit = U_SHIFT; c.sh = SH_RLOG; end
            OP_SRA:  begin c.unit = U_SHIFT; c.sh = SH_RARI; end
            OP_SLLV: begin c.unit = U_SHIFT; c.sh = SH_LEFT; c.var_amt = 1'b1; end
            OP_SRLV: begin c.unit = U_SHIFT; c.sh = SH_RLOG; c.var_amt = 1'b1; end
            OP_SRAV: begin c.unit = U_SHIFT; c.sh = SH_RARI; c.var_amt = 1'b1; end
            OP_LUI:  begin c.unit = U_UPPER; end
            default: begin c.unit = U_NONE; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             ovf_raw,
    output logic             lt_signed
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;

    always_comb begin
        b_eff     = sub ? ~b : b;
        full      = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        sum       = full[WIDTH-1:0];
        ovf_raw   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        // operand signs decide when they differ, so overflow cannot corrupt the compare
        lt_signed = (a[MSB] != b[MSB]) ? a[MSB] : sum[MSB];
    end

    logic [WIDTH:0] wide_ref;
    always_comb begin
        wide_ref = sub ? ({a[MSB], a} - {b[MSB], b}) : ({a[MSB], a} + {b[MSB], b});
        AST_OVF_WIDE: assert (ovf_raw == (wide_ref[WIDTH] != wide_ref[WIDTH-1]))
            else $error("overflow disagrees with widened result"); // R2
        if (sub) begin
            AST_LT_SIGNED: assert (lt_signed == ($signed(a) < $signed(b)))
                else $error("signed less-than wrong"); // R4
        end
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_e           lg,
    output logic [WIDTH-1:0] res
);
    always_comb begin
        case (lg)
            LG_AND:  res = a & b;
            LG_OR:   res = a | b;
            LG_XOR:  res = a ^ b;
            default: res = ~(a | b);
        endcase
    end

    always_comb begin
        if (lg == LG_NOR) begin
            AST_NOR_DISJOINT: assert (((res & (a | b)) == '0) && ((res | a | b) == '1))
                else $error("nor result not complement of or"); // R3
        end
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] val,
    input  logic [SHW-1:0]   amt,
    input  shift_e           mode,
    output logic [WIDTH-1:0] res
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] val_rev;
    logic [WIDTH-1:0] net_in;
    logic [WIDTH-1:0] net_out;
    logic [WIDTH-1:0] out_rev;
    logic             fill;
    logic [WIDTH-1:0] stage [0:SHW];

    // left shifts run through the right-shift network with bits mirrored
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_mirror
            assign val_rev[gi] = val[MSB-gi];
            assign out_rev[gi] = net_out[MSB-gi];
        end
    endgenerate

    assign fill     = (mode == SH_RARI) && val[MSB];
    assign net_in   = (mode == SH_LEFT) ? val_rev : val;
    assign stage[0] = net_in;

    genvar gk;
    generate
        for (gk = 0; gk < SHW; gk++) begin : g_stage
            localparam int STEP = 1 << gk;
            assign stage[gk+1] = amt[gk]
                ? {{STEP{fill}}, stage[gk][WIDTH-1:STEP]}
                : stage[gk];
        end
    endgenerate

    assign net_out = stage[SHW];
    assign res     = (mode == SH_LEFT) ? out_rev : net_out;

    logic [WIDTH-1:0] ref_val;
    always_comb begin
        case (mode)
            SH_LEFT: ref_val = val << amt;
            SH_RLOG: ref_val = val >> amt;
            default: ref_val = $unsigned($signed(val) >>> amt);
        endcase
        AST_SHIFT_MATCH: assert (res == ref_val)
            else $error("shift network mismatch"); // R5
        if (mode == SH_RARI) begin
            AST_SIGN_FILL: assert (res[MSB] == val[MSB])
                else $error("arithmetic shift lost sign"); // R5
        end
        if (mode == SH_RLOG && amt != '0) begin
            AST_ZERO_FILL: assert (res[MSB] == 1'b0)
                else $error("logical shift filled ones"); // R5
        end
    end

endmodule

// File: rtl/int_alu.sv
module int_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH),
    localparam int HALF = WIDTH / 2
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [SHW-1:0]   sh_const,
    input  logic [4:0]       alu_op,
    output logic [WIDTH-1:0] alu_out,
    output logic             is_zero,
    output logic             sig_ovf
);
    ctrl_t            ctl;
    logic [WIDTH-1:0] arith_res;
    logic             arith_ovf;
    logic             arith_lt;
    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] shift_res;
    logic [SHW-1:0]   shift_amt;
    logic [WIDTH-1:0] upper_res;

    assign ctl = decode_op(alu_op);

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a         (opnd_a),
        .b         (opnd_b),
        .sub       (ctl.sub),
        .sum       (arith_res),
        .ovf_raw   (arith_ovf),
        .lt_signed (arith_lt)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a   (opnd_a),
        .b   (opnd_b),
        .lg  (ctl.lg),
        .res (logic_res)
    );

    assign shift_amt = ctl.var_amt ? opnd_a[SHW-1:0] : sh_const;

    alu_shifter #(.WIDTH(WIDTH)) u_shift (
        .val  (opnd_b),
        .amt  (shift_amt),
        .mode (ctl.sh),
        .res  (shift_res)
    );

    assign upper_res = {opnd_b[HALF-1:0], {(WIDTH-HALF){1'b0}}};

    always_comb begin
        case (ctl.unit)
            U_ARITH: alu_out = arith_res;
            U_LOGIC: alu_out = logic_res;
            U_SLT:   alu_out = {{(WIDTH-1){1'b0}}, arith_lt};
            U_SHIFT: alu_out = shift_res;
            U_UPPER: alu_out = upper_res;
            default: alu_out = '0;
        endcase
        sig_ovf = (ctl.unit == U_ARITH) && ctl.trap && arith_ovf;
        is_zero = (alu_out == '0);
    end

    always_comb begin
        if (sig_ovf) begin
            AST_NO_OVERFLOW: assert (alu_op == OP_ADD || alu_op == OP_SUB)
                else $error("overflow raised by non-trapping code"); // R2
        end
        if (alu_op > OP_LUI) begin
            AST_UNUSED_CODE: assert (is_zero && !sig_ovf)
                else $error("unused code produced output"); // R9
        end
        if (ctl.unit == U_UPPER) begin
            AST_UPPER_ZERO: assert (is_zero == (opnd_b[HALF-1:0] == '0))
                else $error("upper immediate zero flag wrong"); // R7
        end
    end

endmodule

// File: tb/sim_int_alu.sv
module sim_int_alu;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  sh_const = '0;
    logic [4:0]  alu_op = '0;
    logic [31:0] alu_out;
    logic        is_zero;
    logic        sig_ovf;

    int_alu u0 (
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .sh_const (sh_const),
        .alu_op   (alu_op),
        .alu_out  (alu_out),
        .is_zero  (is_zero),
        .sig_ovf  (sig_ovf)
    );

    typedef struct {
        logic [31:0] res;
        logic        ovf;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                   input logic [4:0] sc, input logic [4:0] op);
        exp_t e;
        logic [63:0] wa, wb, ws;
        wa = {{32{a[31]}}, a};
        wb = {{32{b[31]}}, b};
        e.res = 32'h0;
        e.ovf = 1'b0;
        e.tag = "R9";
        case (op)
            5'd0, 5'd1: begin
                ws = wa + wb; e.res = ws[31:0];
                e.ovf = (op == 5'd0) && ($signed(ws) > 64'sd2147483647 || $signed(ws) < -64'sd2147483648);
                e.tag = "R1/R2";
            end
            5'd2, 5'd3: begin
                ws = wa - wb; e.res = ws[31:0];
                e.ovf = (op == 5'd2) && ($signed(ws) > 64'sd2147483647 || $signed(ws) < -64'sd2147483648);
                e.tag = "R1/R2";
            end
            5'd4: begin e.res = a & b; e.tag = "R3"; end
            5'd5: begin e.res = a | b; e.tag = "R3"; end
            5'd6: begin e.res = a ^ b; e.tag = "R3"; end
            5'd7: begin e.res = ~(a | b); e.tag = "R3"; end
            5'd8: begin e.res = ($signed(wa) < $signed(wb)) ? 32'd1 : 32'd0; e.tag = "R4"; end
            5'd9:  begin e.res = b << sc; e.tag = "R5"; end
            5'd10: begin e.res = b >> sc; e.tag = "R5"; end
            5'd11: begin ws = wb >> sc; e.res = ws[31:0]; e.tag = "R5"; end
            5'd12: begin e.res = b << a[4:0]; e.tag = "R6"; end
            5'd13: begin e.res = b >> a[4:0]; e.tag = "R6"; end
            5'd14: begin ws = wb >> a[4:0]; e.res = ws[31:0]; e.tag = "R6"; end
            5'd15: begin e.res = {b[15:0], 16'h0}; e.tag = "R7"; end
            default: ;
        endcase
        return e;
    endfunction

    task automatic drive(input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] sc, input logic [4:0] op);
        @(posedge clk);
        opnd_a   = a;
        opnd_b   = b;
        sh_const = sc;
        alu_op   = op;
        exp_q.push_back(model(a, b, sc, op));
    endtask

    task automatic drive_exp(input logic [31:0] a, input logic [31:0] b,
                             input logic [4:0] sc, input logic [4:0] op,
                             input logic [31:0] want, input logic want_ovf, input string tag);
        exp_t e;
        @(posedge clk);
        opnd_a   = a;
        opnd_b   = b;
        sh_const = sc;
        alu_op   = op;
        e.res = want;
        e.ovf = want_ovf;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compare half a period after each drive
    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (alu_out !== e.res || sig_ovf !== e.ovf) begin
                errors++;
                $display("FAIL %s op=%0d result=%h ovf=%b expected result=%h ovf=%b",
                         e.tag, alu_op, alu_out, sig_ovf, e.res, e.ovf);
            end
            checks++;
            if (is_zero !== (e.res == 32'h0)) begin
                errors++;
                $display("FAIL R8 op=%0d zero=%b expected zero=%b", alu_op, is_zero, (e.res == 32'h0));
            end
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-time state: all-zero inputs give zero result
        drive_exp(32'h0, 32'h0, 5'd0, 5'd0, 32'h0, 1'b0, "R8 reset");
        // R1 R2 add forms
        drive_exp(32'd7, 32'd5, 5'd0, 5'd0, 32'd12, 1'b0, "R1 add");
        drive_exp(32'h7fffffff, 32'd1, 5'd0, 5'd0, 32'h80000000, 1'b1, "R2 add ovf");
        drive_exp(32'h7fffffff, 32'd1, 5'd0, 5'd1, 32'h80000000, 1'b0, "R2 addu no ovf");
        drive_exp(32'h80000000, 32'h80000000, 5'd0, 5'd0, 32'h0, 1'b1, "R2 neg ovf");
        // R1 R2 subtract forms
        drive_exp(32'd5, 32'd7, 5'd0, 5'd2, 32'hfffffffe, 1'b0, "R1 sub");
        drive_exp(32'h80000000, 32'd1, 5'd0, 5'd2, 32'h7fffffff, 1'b1, "R2 sub ovf");
        drive_exp(32'h80000000, 32'd1, 5'd0, 5'd3, 32'h7fffffff, 1'b0, "R2 subu no ovf");
        drive_exp(32'h1234, 32'h1234, 5'd0, 5'd2, 32'h0, 1'b0, "R8 sub equal");
        // R3 logic
        drive_exp(32'hf0f0ff00, 32'h0ff0f0f0, 5'd0, 5'd4, 32'h00f0f000, 1'b0, "R3 and");
        drive_exp(32'hf0f0ff00, 32'h0ff0f0f0, 5'd0, 5'd5, 32'hfff0fff0, 1'b0, "R3 or");
        drive_exp(32'hf0f0ff00, 32'h0ff0f0f0, 5'd0, 5'd6, 32'hff000ff0, 1'b0, "R3 xor");
        drive_exp(32'hf0f0ff00, 32'h0ff0f0f0, 5'd0, 5'd7, 32'h000f000f, 1'b0, "R3 nor");
        drive_exp(32'h0, 32'h0, 5'd0, 5'd7, 32'hffffffff, 1'b0, "R3 nor zero");
        // R4 signed compare, including overflowing difference
        drive_exp(32'hffffffff, 32'd1, 5'd0, 5'd8, 32'd1, 1'b0, "R4 neg<pos");
        drive_exp(32'h7fffffff, 32'h80000000, 5'd0, 5'd8, 32'd0, 1'b0, "R4 max vs min");
        drive_exp(32'h80000000, 32'h7fffffff, 5'd0, 5'd8, 32'd1, 1'b0, "R4 min vs max");
        drive_exp(32'd9, 32'd9, 5'd0, 5'd8, 32'd0, 1'b0, "R4 equal");
        // R5 constant shifts
        drive_exp(32'hdeadbeef, 32'h0000000f, 5'd4, 5'd9, 32'h000000f0, 1'b0, "R5 sll");
        drive_exp(32'h0, 32'h80000000, 5'd31, 5'd10, 32'h00000001, 1'b0, "R5 srl");
        drive_exp(32'h0, 32'h80000000, 5'd4, 5'd11, 32'hf8000000, 1'b0, "R5 sra neg");
        drive_exp(32'h0, 32'h40000000, 5'd4, 5'd11, 32'h04000000, 1'b0, "R5 sra pos");
        drive_exp(32'h0, 32'h12345678, 5'd0, 5'd11, 32'h12345678, 1'b0, "R5 zero count");
        // R6 variable shifts: upper bits of a and sh_const have no effect
        drive_exp(32'hffffffe4, 32'h0000000f, 5'd31, 5'd12, 32'h000000f0, 1'b0, "R6 sllv");
        drive_exp(32'hffffffe4, 32'hf0000000, 5'd1, 5'd13, 32'h0f000000, 1'b0, "R6 srlv");
        drive_exp(32'hffffffe4, 32'hf0000000, 5'd0, 5'd14, 32'hff000000, 1'b0, "R6 srav");
        drive_exp(32'h00000020, 32'h0000abcd, 5'd8, 5'd13, 32'h0000abcd, 1'b0, "R6 count wraps");
        // R7 upper immediate
        drive_exp(32'hffffffff, 32'h1234abcd, 5'd3, 5'd15, 32'habcd0000, 1'b0, "R7 lui");
        drive_exp(32'h0, 32'hffff0000, 5'd0, 5'd15, 32'h0, 1'b0, "R7 lui zero");
        // R9 unused codes
        drive_exp(32'h7fffffff, 32'd1, 5'd3, 5'd16, 32'h0, 1'b0, "R9 code16");
        drive_exp(32'hffffffff, 32'hffffffff, 5'd7, 5'd31, 32'h0, 1'b0, "R9 code31");
        // sweep every code with pseudo-random operands
        lf = 32'hace1_2471;
        for (int i = 0; i < 640; i++) begin
            logic [31:0] ra, rb;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            ra = lf;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            rb = lf ^ {lf[15:0], lf[31:16]};
            if (i % 7 == 0) rb = ra;
            if (i % 11 == 0) ra = {~rb[31], ra[30:0]};
            drive(ra, rb, lf[9:5], 5'(i % 32));
        end
        repeat (3) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule